// File: doc/BRIEF.md
# Condition Code and Branch Unit

This block keeps the four status flags of a processor datapath (negative, zero, overflow, carry) and chooses the next program counter value. The ALU gives it a result word, a carry-out and the signs of its two operands. When the flag-write enable is high, the block captures new flag values at the clock edge. When the enable is low, the stored flags stay as they are.

Each cycle the block also resolves the branch kind of the instruction being issued. The choices are no branch, an unconditional jump, branch-on-equal and branch-on-greater-than-zero. Branch-on-equal compares two register values directly, so it needs no stored flag. Branch-on-greater-than-zero uses only the stored N and Z flags, as they stand before the current edge. The next PC is combinational. It is either the supplied target address or the current PC plus four, modulo 2^ADDR_W.

The overflow rule assumes the ALU supplies the sign of the effective second operand. For a subtraction, that is the inverted sign of the subtrahend. With that input, one rule serves both add and subtract.

Top module: `cond_branch_unit`

## Requirements
- R1: While rst_n is low, flags reads 4'b0000. The layout is flags[3]=N, flags[2]=Z, flags[1]=V, flags[0]=C.
- R2: On a clock edge with flag_wr_en high, flags[3] (N) takes the most significant bit of alu_result.
- R3: On a clock edge with flag_wr_en high, flags[2] (Z) becomes 1 if alu_result is all zeros and 0 otherwise.
- R4: On a clock edge with flag_wr_en high, flags[1] (V) becomes 1 exactly when opnd_a_sign equals opnd_b_sign and the result's top bit differs from them.
- R5: On a clock edge with flag_wr_en high, flags[0] (C) takes alu_carry.
- R6: On a clock edge with flag_wr_en low, all four flags keep their previous values.
- R7: With br_kind 2'b00 (none), next_pc is pc_cur + 4.
- R8: With br_kind 2'b01 (jump), next_pc is tgt_addr whatever the flags and registers hold.
- R9: With br_kind 2'b10 (equal), next_pc is tgt_addr when reg_a equals reg_b, and pc_cur + 4 otherwise.
- R10: With br_kind 2'b11 (greater than zero), next_pc is tgt_addr only when the stored flags[3] and flags[2] are both 0, and pc_cur + 4 otherwise.
- R11: The sequential address wraps modulo 2^ADDR_W, so pc_cur = all ones minus 3 gives next_pc = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_result | input | DATA_W | Result word from the ALU |
| alu_carry | input | 1 | Carry-out of the ALU operation |
| opnd_a_sign | input | 1 | Sign bit of the first operand |
| opnd_b_sign | input | 1 | Sign bit of the effective second operand |
| flag_wr_en | input | 1 | Capture new flags at this edge |
| br_kind | input | 2 | 00 none, 01 jump, 10 equal, 11 greater than zero |
| reg_a | input | DATA_W | First register value for the equality compare |
| reg_b | input | DATA_W | Second register value for the equality compare |
| pc_cur | input | ADDR_W | Current program counter |
| tgt_addr | input | ADDR_W | Branch or jump target address |
| flags | output | 4 | Stored {N, Z, V, C} |
| next_pc | output | ADDR_W | Selected next program counter |

## Verification
The assertions assume that every input is stable and known at each rising edge. They also assume the reset is released away from a clock edge, because the hold and capture properties compare flags with inputs sampled one edge earlier. The bench meets both assumptions. It changes inputs only just after the falling edge and releases reset on a falling edge. It keeps alu_result, the operand signs and the branch fields at defined two-state values in every cycle, including cycles where flag_wr_en is low.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  typedef enum logic [1:0] {
    BK_NONE = 2'b00,
    BK_JUMP = 2'b01,
    BK_EQ   = 2'b10,
    BK_GTZ  = 2'b11
  } br_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_flags_t;

  localparam int unsigned FLAG_W = 4;

  // Signed overflow: both operand signs agree and the result sign does not.
  function automatic logic f_overflow(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  // Equality compare of two register words.
  function automatic logic f_regs_equal(input logic [63:0] a, input logic [63:0] b);
    return (a == b);
  endfunction

  // Greater-than-zero test on the stored flags.
  function automatic logic f_gt_zero(input cc_flags_t f);
    return !f.n && !f.z;
  endfunction

endpackage

// File: rtl/cbu_flag_calc.sv
module cbu_flag_calc
  import cbu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              opnd_a_sign,
  input  logic              opnd_b_sign,
  output cc_flags_t         flags_new
);
  localparam int unsigned MSB = DATA_W - 1;

  logic res_sign;
  logic res_zero;

  assign res_sign = alu_result[MSB];
  assign res_zero = (alu_result == '0);

  always_comb begin
    flags_new.n = res_sign;
    flags_new.z = res_zero;
    flags_new.v = f_overflow(opnd_a_sign, opnd_b_sign, res_sign);
    flags_new.c = alu_carry;
  end
endmodule

// File: rtl/cbu_flag_reg.sv
module cbu_flag_reg
  import cbu_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  cc_flags_t flags_new,
  output cc_flags_t flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (wr_en) begin
      flags_q <= flags_new;
    end
  end
endmodule

// File: rtl/cbu_branch_resolve.sv
module cbu_branch_resolve
  import cbu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic [1:0]        br_kind,
  input  cc_flags_t         flags_q,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic              eq_hit,
  output logic              gt_hit,
  output logic              take_branch,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] next_pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  logic [63:0] a_ext;
  logic [63:0] b_ext;

  assign a_ext  = 64'(reg_a);
  assign b_ext  = 64'(reg_b);
  assign eq_hit = f_regs_equal(a_ext, b_ext);
  assign gt_hit = f_gt_zero(flags_q);
  assign seq_pc = pc_cur + STEP;

  always_comb begin
    unique case (br_kind_e'(br_kind))
      BK_JUMP: take_branch = 1'b1;
      BK_EQ:   take_branch = eq_hit;
      BK_GTZ:  take_branch = gt_hit;
      default: take_branch = 1'b0;
    endcase
  end

  assign next_pc = take_branch ? tgt_addr : seq_pc;
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              opnd_a_sign,
  input  logic              opnd_b_sign,
  input  logic              flag_wr_en,
  input  logic [1:0]        br_kind,
  input  logic [DATA_W-1:0] reg_a,
  input  logic [DATA_W-1:0] reg_b,
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic [3:0]        flags,
  output logic [ADDR_W-1:0] next_pc
);
  cc_flags_t         flags_new;
  cc_flags_t         flags_q;
  logic              eq_hit;
  logic              gt_hit;
  logic              take_branch;
  logic [ADDR_W-1:0] seq_pc;

  cbu_flag_calc #(.DATA_W(DATA_W)) u_calc (
    .alu_result (alu_result),
    .alu_carry  (alu_carry),
    .opnd_a_sign(opnd_a_sign),
    .opnd_b_sign(opnd_b_sign),
    .flags_new  (flags_new)
  );

  cbu_flag_reg u_freg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (flag_wr_en),
    .flags_new(flags_new),
    .flags_q  (flags_q)
  );

  cbu_branch_resolve #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .PC_STEP(PC_STEP)
  ) u_br (
    .br_kind    (br_kind),
    .flags_q    (flags_q),
    .reg_a      (reg_a),
    .reg_b      (reg_b),
    .pc_cur     (pc_cur),
    .tgt_addr   (tgt_addr),
    .eq_hit     (eq_hit),
    .gt_hit     (gt_hit),
    .take_branch(take_branch),
    .seq_pc     (seq_pc),
    .next_pc    (next_pc)
  );

  assign flags = flags_q;
endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] alu_result,
  input logic              alu_carry,
  input logic              opnd_a_sign,
  input logic              opnd_b_sign,
  input logic              flag_wr_en,
  input logic [1:0]        br_kind,
  input logic [DATA_W-1:0] reg_a,
  input logic [DATA_W-1:0] reg_b,
  input logic [ADDR_W-1:0] pc_cur,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic [3:0]        flags,
  input logic [ADDR_W-1:0] next_pc,
  input logic              take_branch
);
  localparam logic [ADDR_W-1:0] FOUR = ADDR_W'(4);

  assert_n_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr_en |=> flags[3] == $past(alu_result[DATA_W-1]));

  assert_z_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr_en |=> flags[2] == ($past(alu_result) == '0));

  assert_v_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_en && (opnd_a_sign != opnd_b_sign)) |=> !flags[1]);

  assert_c_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr_en |=> flags[0] == $past(alu_carry));

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr_en |=> $stable(flags));

  assert_none_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'b00) |-> (next_pc == pc_cur + FOUR) && !take_branch);

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'b01) |-> next_pc == tgt_addr);

  assert_eq_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'b10 && reg_a == reg_b) |-> next_pc == tgt_addr);

  assert_gtz_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'b11 && (flags[3] || flags[2])) |-> next_pc == pc_cur + FOUR);
endmodule

bind cond_branch_unit cbu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cbu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alu_result (alu_result),
  .alu_carry  (alu_carry),
  .opnd_a_sign(opnd_a_sign),
  .opnd_b_sign(opnd_b_sign),
  .flag_wr_en (flag_wr_en),
  .br_kind    (br_kind),
  .reg_a      (reg_a),
  .reg_b      (reg_b),
  .pc_cur     (pc_cur),
  .tgt_addr   (tgt_addr),
  .flags      (flags),
  .next_pc    (next_pc),
  .take_branch(take_branch)
);

// File: tb/cond_branch_unit_bench.sv
module cond_branch_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] alu_result = '0;
  logic          alu_carry = 1'b0;
  logic          opnd_a_sign = 1'b0;
  logic          opnd_b_sign = 1'b0;
  logic          flag_wr_en = 1'b0;
  logic [1:0]    br_kind = 2'b00;
  logic [DW-1:0] reg_a = '0;
  logic [DW-1:0] reg_b = '0;
  logic [AW-1:0] pc_cur = '0;
  logic [AW-1:0] tgt_addr = '0;
  logic [3:0]    flags;
  logic [AW-1:0] next_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference flags held as separate bits: n z v c
  bit m_n, m_z, m_v, m_c;

  cond_branch_unit u_cond_branch_unit (
    .clk(clk), .rst_n(rst_n), .alu_result(alu_result), .alu_carry(alu_carry),
    .opnd_a_sign(opnd_a_sign), .opnd_b_sign(opnd_b_sign), .flag_wr_en(flag_wr_en),
    .br_kind(br_kind), .reg_a(reg_a), .reg_b(reg_b), .pc_cur(pc_cur),
    .tgt_addr(tgt_addr), .flags(flags), .next_pc(next_pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: drive after falling edge, check next_pc, clock, check flags.
  task automatic cycle(input logic [DW-1:0] res, input bit cy, input bit sa, input bit sb,
                       input bit en, input logic [1:0] kind, input logic [DW-1:0] ra,
                       input logic [DW-1:0] rb, input logic [AW-1:0] pc,
                       input logic [AW-1:0] tg);
    longint exp_pc;
    string  tag;
    bit     r_msb;
    @(negedge clk);
    alu_result = res; alu_carry = cy; opnd_a_sign = sa; opnd_b_sign = sb;
    flag_wr_en = en; br_kind = kind; reg_a = ra; reg_b = rb; pc_cur = pc; tgt_addr = tg;
    #1;
    exp_pc = (longint'(pc) + 4) % (longint'(1) << AW);
    case (kind)
      2'b00: tag = "R7 none";
      2'b01: begin tag = "R8 jump"; exp_pc = tg; end
      2'b10: begin tag = "R9 equal"; if (ra == rb) exp_pc = tg; end
      default: begin tag = "R10 gtz"; if (m_n == 0 && m_z == 0) exp_pc = tg; end
    endcase
    if (kind == 2'b00 && pc > 32'hFFFF_FFF0) tag = "R11 wrap";
    chk(tag, next_pc, exp_pc);
    @(posedge clk);
    if (en) begin
      r_msb = res[DW-1];
      m_n = r_msb;
      m_z = 1;
      for (int i = 0; i < DW; i++) if (res[i]) m_z = 0;
      m_v = sa ? (sb && !r_msb) : (!sb && r_msb);
      m_c = cy;
    end
    #1;
    if (en) begin
      chk("R2 N", flags[3], m_n);
      chk("R3 Z", flags[2], m_z);
      chk("R4 V", flags[1], m_v);
      chk("R5 C", flags[0], m_c);
    end else begin
      chk("R6 hold", flags, {m_n, m_z, m_v, m_c});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_n = 0; m_z = 0; m_v = 0; m_c = 0;
    #(CLK_PERIOD * 2 + 1);
    chk("R1 reset flags", flags, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 zero result, then GTZ must fall through (Z=1)
    cycle(32'h0, 1, 0, 0, 1, 2'b00, 0, 0, 32'h100, 32'h800);
    cycle(32'h5, 0, 0, 0, 0, 2'b11, 0, 0, 32'h104, 32'h800);
    // R2 negative result, R4 positive overflow
    cycle(32'h8000_0000, 0, 0, 0, 1, 2'b01, 1, 2, 32'h108, 32'h900);
    cycle(32'h1, 0, 0, 0, 0, 2'b11, 0, 0, 32'h10C, 32'hA00);
    // R4 negative overflow with carry, R5
    cycle(32'h0000_0010, 1, 1, 1, 1, 2'b10, 32'h55, 32'h55, 32'h110, 32'hB00);
    // GTZ now taken: N=0 Z=0 (R10)
    cycle(32'hFFFF_FFFF, 0, 1, 0, 0, 2'b11, 0, 0, 32'h114, 32'hC00);
    // R9 not equal
    cycle(32'h7, 0, 1, 0, 1, 2'b10, 32'h55, 32'h56, 32'h118, 32'hD00);
    // R6 hold with odd inputs
    cycle(32'h0, 1, 1, 1, 0, 2'b00, 0, 0, 32'h11C, 0);
    // R11 wraparound
    cycle(32'h3, 0, 0, 0, 1, 2'b00, 0, 0, 32'hFFFF_FFFC, 32'h40);
    cycle(32'h3, 0, 0, 0, 1, 2'b10, 9, 9, 32'hFFFF_FFFC, 32'h44);

    for (int k = 0; k < 300; k++) begin
      logic [DW-1:0] r;
      logic [DW-1:0] a;
      r = ($urandom % 4 == 0) ? '0 : $urandom;
      a = $urandom;
      cycle(r, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, 2'($urandom),
            a, ($urandom % 2) ? a : $urandom, $urandom & 32'hFFFF_FFFC, $urandom);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule